// File: doc/BRIEF.md
# Hardware Task Switch Sequencer

This block carries out the memory side of a hardware context switch between two task state records. On a start pulse it captures the base addresses of the outgoing and incoming records, the cause of the switch, the outgoing task's selector and the live architectural registers. It then steps through a fixed list of single-word memory transactions. First it stores the live state into the outgoing record. Next, for a call-type or interrupt-type switch, it writes the back-link into the incoming record. Last it reads the incoming record, starting with the page-directory base.

Each record field sits at a fixed word offset from its record base. The byte address is the base plus four times the offset. The offsets are parameters. The memory port carries one transaction at a time: a request is held steady until the memory acknowledges it. The values read back appear on the load outputs. A one-cycle done pulse marks a completed switch. An error response from memory stops the sequence and raises a fault.

Top module: `task_switch_seq`

## Requirements
- R1: While reset is asserted and right after it, busy, done, fault and mem_req are all low.
- R2: A start pulse seen while idle captures cause, both bases, old_sel and every cur_* value, and busy rises in the next cycle. Later changes to those inputs do not affect the sequence. A start pulse while busy is ignored.
- R3: The save phase issues 16 writes to the outgoing record, in this order: instruction pointer (word 8), flags (word 9), general registers 0..7 (words 10..17), segment selectors 0..5 (words 18..23). Selectors are zero-extended to 32 bits. Every save write completes before any read is issued.
- R4: The restore phase issues reads from the incoming record. The page-directory base (word 7) is read first. Then come the instruction pointer, flags, general registers 0..7 and segment selectors 0..5, using the same words as in R3, and finally the local descriptor table selector (word 24).
- R5: The cause is encoded as 0 = jump, 1 = call, 2 = interrupt, 3 = treated like call. For any cause other than 0, exactly one write of {16'h0, old_sel} goes to word 0 of the incoming record, between the last save write and the first read. For cause 0, word 0 of the incoming record is left unchanged.
- R6: No other word is accessed. In particular, the privilege-stack words 1..6 and the I/O bitmap pointer word 25 are never accessed, and the page-directory base and descriptor-table selector words are never written.
- R7: mem_req is high exactly while busy. While a request is waiting for mem_ack, mem_addr, mem_we and mem_wdata hold steady.
- R8: After a completed switch, ld_cr3, ld_eip and ld_eflags hold the words read. ld_gpr holds the general registers (register i in bits 32i+31:32i). ld_seg and ld_ldt hold the low 16 bits of the words read (selector i in bits 16i+15:16i).
- R9: done is high for exactly one cycle: the cycle after the final read is acknowledged. busy falls in that same cycle.
- R10: If mem_ack arrives with mem_err high, no further requests are issued, done does not pulse, and from the next cycle fault stays high until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a switch (used while idle) |
| cause | input | 2 | 0 jump, 1 call, 2 interrupt, 3 as call |
| old_base | input | 32 | Byte base of the outgoing record |
| new_base | input | 32 | Byte base of the incoming record |
| old_sel | input | 16 | Selector of the outgoing record, written as the back-link |
| cur_eip | input | 32 | Live instruction pointer |
| cur_eflags | input | 32 | Live flags |
| cur_gpr | input | 256 | Eight live general registers, packed |
| cur_seg | input | 96 | Six live segment selectors, packed |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Memory error ended the last sequence |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Request byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request accepted and completed |
| mem_err | input | 1 | Error response, valid with mem_ack |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| ld_cr3 | output | 32 | Loaded page-directory base |
| ld_ldt | output | 16 | Loaded descriptor-table selector |
| ld_eip | output | 32 | Loaded instruction pointer |
| ld_eflags | output | 32 | Loaded flags |
| ld_gpr | output | 256 | Loaded general registers, packed |
| ld_seg | output | 96 | Loaded segment selectors, packed |

## Verification
The assertions assume that memory acknowledges only while mem_req is high, and that mem_err is meaningful only together with mem_ack. They also assume that the two record bases are far enough apart that the back-link word of the incoming record never aliases a word of the outgoing record. The bench's memory responder answers only pending requests, with a latency of zero to three cycles that varies per transaction. It injects errors only on acknowledged transactions, and it places every record pair in its own non-overlapping address window.

// File: rtl/task_switch_seq.sv
module task_switch_seq #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int SELW = 16,
  parameter int NGPR = 8,
  parameter int NSEG = 6,
  parameter int OFF_LINK = 0,
  parameter int OFF_CR3 = 7,
  parameter int OFF_EIP = 8,
  parameter int OFF_EFLAGS = 9,
  parameter int OFF_GPR = 10,
  parameter int OFF_SEG = 18,
  parameter int OFF_LDT = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [1:0]           cause,
  input  logic [AW-1:0]        old_base,
  input  logic [AW-1:0]        new_base,
  input  logic [SELW-1:0]      old_sel,
  input  logic [DW-1:0]        cur_eip,
  input  logic [DW-1:0]        cur_eflags,
  input  logic [NGPR*DW-1:0]   cur_gpr,
  input  logic [NSEG*SELW-1:0] cur_seg,
  output logic                 busy,
  output logic                 done,
  output logic                 fault,
  output logic                 mem_req,
  output logic                 mem_we,
  output logic [AW-1:0]        mem_addr,
  output logic [DW-1:0]        mem_wdata,
  input  logic                 mem_ack,
  input  logic                 mem_err,
  input  logic [DW-1:0]        mem_rdata,
  output logic [DW-1:0]        ld_cr3,
  output logic [SELW-1:0]      ld_ldt,
  output logic [DW-1:0]        ld_eip,
  output logic [DW-1:0]        ld_eflags,
  output logic [NGPR*DW-1:0]   ld_gpr,
  output logic [NSEG*SELW-1:0] ld_seg
);
  localparam int NFLD = 2 + NGPR + NSEG;
  localparam int STEP_LINK = NFLD;
  localparam int STEP_CR3 = NFLD + 1;
  localparam int STEP_LDT = STEP_CR3 + NFLD + 1;
  localparam int SW = $clog2(STEP_LDT + 1);
  localparam int FW = $clog2(NFLD);

  logic [SW-1:0]          step;
  logic [1:0]             cause_q;
  logic [AW-1:0]          obase_q, nbase_q;
  logic [SELW-1:0]        osel_q;
  logic [NFLD-1:0][DW-1:0] snap;
  logic                   saw_read;

  function automatic int fld_off(input int f);
    if (f == 0) return OFF_EIP;
    if (f == 1) return OFF_EFLAGS;
    if (f < 2 + NGPR) return OFF_GPR + f - 2;
    return OFF_SEG + f - 2 - NGPR;
  endfunction

  logic in_save, in_link, in_cr3, in_ldt;
  logic [FW-1:0] fidx;
  int woff;

  assign in_save = step < SW'(STEP_LINK);
  assign in_link = step == SW'(STEP_LINK);
  assign in_cr3  = step == SW'(STEP_CR3);
  assign in_ldt  = step == SW'(STEP_LDT);
  assign fidx    = in_save ? FW'(step) : FW'(step - SW'(STEP_CR3 + 1));

  always_comb begin
    woff = fld_off(int'(fidx));
    if (in_link)     woff = OFF_LINK;
    else if (in_cr3) woff = OFF_CR3;
    else if (in_ldt) woff = OFF_LDT;
  end

  assign mem_req   = busy;
  assign mem_we    = busy & (in_save | in_link);
  assign mem_addr  = (in_save ? obase_q : nbase_q) + (AW'(woff) << 2);
  assign mem_wdata = !busy   ? '0 :
                     in_save ? snap[fidx] :
                     in_link ? DW'(osel_q) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      fault <= 1'b0;
      step <= '0;
      cause_q <= '0;
      obase_q <= '0;
      nbase_q <= '0;
      osel_q <= '0;
      snap <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          fault <= 1'b0;
          step <= '0;
          cause_q <= cause;
          obase_q <= old_base;
          nbase_q <= new_base;
          osel_q <= old_sel;
          snap[0] <= cur_eip;
          snap[1] <= cur_eflags;
          for (int i = 0; i < NGPR; i++) snap[2 + i] <= cur_gpr[i*DW +: DW];
          for (int i = 0; i < NSEG; i++) snap[2 + NGPR + i] <= DW'(cur_seg[i*SELW +: SELW]);
        end
      end else if (mem_ack) begin
        if (mem_err) begin
          busy <= 1'b0;
          fault <= 1'b1;
        end else if (in_ldt) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else if (step == SW'(STEP_LINK - 1) && cause_q == 2'd0) begin
          step <= step + SW'(2);
        end else begin
          step <= step + SW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_cr3 <= '0;
      ld_ldt <= '0;
      ld_eip <= '0;
      ld_eflags <= '0;
      ld_gpr <= '0;
      ld_seg <= '0;
    end else if (busy && mem_ack && !mem_err && !mem_we) begin
      if (in_cr3)                       ld_cr3 <= mem_rdata;
      else if (in_ldt)                  ld_ldt <= mem_rdata[SELW-1:0];
      else if (fidx == FW'(0))          ld_eip <= mem_rdata;
      else if (fidx == FW'(1))          ld_eflags <= mem_rdata;
      else if (int'(fidx) < 2 + NGPR)   ld_gpr[(int'(fidx) - 2)*DW +: DW] <= mem_rdata;
      else                              ld_seg[(int'(fidx) - 2 - NGPR)*SELW +: SELW] <= mem_rdata[SELW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           saw_read <= 1'b0;
    else if (!busy && start)              saw_read <= 1'b0;
    else if (busy && mem_ack && !mem_we)  saw_read <= 1'b1;
  end

  assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  assert_save_before_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> !saw_read);

  assert_cr3_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we && !saw_read |-> mem_addr == nbase_q + (AW'(OFF_CR3) << 2));

  assert_link_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && mem_addr == nbase_q + (AW'(OFF_LINK) << 2) |-> cause_q != 2'd0);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_fault_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !mem_req && !done);
endmodule

// File: tb/sim_task_switch_seq.sv
`timescale 1ns/1ps
module sim_task_switch_seq;
  localparam int B_LINK = 0, B_CR3 = 7, B_EIP = 8, B_EFL = 9, B_GPR = 10, B_SEG = 18, B_LDT = 24, B_IOMAP = 25;
  localparam int WD_LIMIT = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] cause = '0;
  logic [31:0] old_base = '0, new_base = '0;
  logic [15:0] old_sel = '0;
  logic [31:0] cur_eip = '0, cur_eflags = '0;
  logic [255:0] cur_gpr = '0;
  logic [95:0] cur_seg = '0;
  logic busy, done, fault, mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic mem_ack = 1'b0, mem_err = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic [31:0] ld_cr3, ld_eip, ld_eflags;
  logic [15:0] ld_ldt;
  logic [255:0] ld_gpr;
  logic [95:0] ld_seg;

  task_switch_seq u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .cause(cause),
    .old_base(old_base), .new_base(new_base), .old_sel(old_sel),
    .cur_eip(cur_eip), .cur_eflags(cur_eflags), .cur_gpr(cur_gpr), .cur_seg(cur_seg),
    .busy(busy), .done(done), .fault(fault),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
    .ld_cr3(ld_cr3), .ld_ldt(ld_ldt), .ld_eip(ld_eip), .ld_eflags(ld_eflags),
    .ld_gpr(ld_gpr), .ld_seg(ld_seg)
  );

  always #4 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  logic [31:0] mem [logic [31:0]];
  bit          q_we [$];
  logic [31:0] q_addr [$];
  logic [31:0] q_wd [$];
  string       q_tag [$];
  bit m_busy = 0, m_done = 0, m_fault = 0;
  int wait_n = 0, lat = 0, txn_n = 0, seed = 0, err_at = -1;
  logic [31:0] m_nb = '0;

  function automatic logic [31:0] dflt(input logic [31:0] a);
    return a * 32'h9E37_79B9 + 32'h1234_5678;
  endfunction

  function automatic logic [31:0] rd(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return dflt(a);
  endfunction

  task automatic chk(input bit ok, input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic push(input bit we, input logic [31:0] a, input logic [31:0] d, input string tg);
    q_we.push_back(we); q_addr.push_back(a); q_wd.push_back(d); q_tag.push_back(tg);
  endtask

  function automatic int boff(input int f);
    if (f == 0) return B_EIP;
    if (f == 1) return B_EFL;
    if (f < 10) return B_GPR + f - 2;
    return B_SEG + f - 10;
  endfunction

  function automatic logic [31:0] live(input int f);
    if (f == 0) return cur_eip;
    if (f == 1) return cur_eflags;
    if (f < 10) return cur_gpr[(f-2)*32 +: 32];
    return {16'h0, cur_seg[(f-10)*16 +: 16]};
  endfunction

  task automatic build_model();
    q_we.delete(); q_addr.delete(); q_wd.delete(); q_tag.delete();
    for (int f = 0; f < 16; f++) push(1'b1, old_base + 32'(boff(f) * 4), live(f), "R3");
    if (cause != 2'd0) push(1'b1, new_base + 32'(B_LINK * 4), {16'h0, old_sel}, "R5");
    push(1'b0, new_base + 32'(B_CR3 * 4), '0, "R4");
    for (int f = 0; f < 16; f++) push(1'b0, new_base + 32'(boff(f) * 4), '0, "R4");
    push(1'b0, new_base + 32'(B_LDT * 4), '0, "R4");
    m_nb = new_base;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc == WD_LIMIT) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=<%0d", cyc, WD_LIMIT);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_fault = 0; mem_ack = 0; mem_err = 0;
    end else begin
      chk(busy === m_busy, "R2", "busy", 32'(busy), 32'(m_busy));
      chk(mem_req === m_busy, "R7", "mem_req", 32'(mem_req), 32'(m_busy));
      chk(done === m_done, "R9", "done", 32'(done), 32'(m_done));
      chk(fault === m_fault, "R10", "fault", 32'(fault), 32'(m_fault));
      m_done = 0; mem_ack = 0; mem_err = 0;
      if (m_busy) begin
        if (mem_req && wait_n >= lat) begin
          if (q_addr.size() == 0) begin
            chk(1'b0, "R6", "unexpected access", mem_addr, '0);
          end else begin
            automatic bit we = q_we.pop_front();
            automatic logic [31:0] a = q_addr.pop_front();
            automatic logic [31:0] d = q_wd.pop_front();
            automatic string tg = q_tag.pop_front();
            chk(mem_addr === a && mem_we === we, tg, "address/direction", mem_addr, a);
            if (we) chk(mem_wdata === d, tg, "write data", mem_wdata, d);
          end
          mem_ack = 1;
          if (txn_n == err_at) begin
            mem_err = 1; m_busy = 0; m_fault = 1;
          end else begin
            if (mem_we) mem[mem_addr] = mem_wdata;
            else mem_rdata = rd(mem_addr);
            if (q_addr.size() == 0) begin m_busy = 0; m_done = 1; end
          end
          txn_n++; wait_n = 0; lat = (txn_n * 3 + seed) % 4;
        end else begin
          wait_n++;
        end
      end else if (start) begin
        build_model();
        m_busy = 1; m_fault = 0; txn_n = 0; wait_n = 0; lat = seed % 4;
      end
    end
  end

  task automatic set_inputs(input int k, input logic [1:0] c);
    cause = c;
    old_base = 32'h0001_0000 + 32'(k) * 32'h200;
    new_base = 32'h0001_0100 + 32'(k) * 32'h200;
    old_sel = 16'h0040 + 16'(k * 8);
    cur_eip = 32'h0040_0000 + 32'(k);
    cur_eflags = 32'h0000_0202 ^ 32'(k << 8);
    for (int i = 0; i < 8; i++) cur_gpr[i*32 +: 32] = 32'hA000_0000 + 32'(k * 256 + i);
    for (int i = 0; i < 6; i++) cur_seg[i*16 +: 16] = 16'h1000 + 16'(k * 16 + i);
  endtask

  task automatic scramble();
    cause = ~cause; old_base = 32'hDEAD_0000; new_base = 32'hBEEF_0000; old_sel = 16'hFFFF;
    cur_eip = '1; cur_eflags = '1; cur_gpr = '1; cur_seg = '1;
  endtask

  task automatic run(input int k, input logic [1:0] c, input int sd, input int ea, input bit poke);
    logic [31:0] ob, nb;
    logic [15:0] sel;
    seed = sd; err_at = ea;
    @(posedge clk); #2;
    set_inputs(k, c);
    ob = old_base; nb = new_base; sel = old_sel;
    start = 1'b1;
    @(posedge clk); #2;
    start = 1'b0;
    scramble();
    if (poke) begin
      repeat (6) @(posedge clk);
      #2 start = 1'b1;
      @(posedge clk); #2 start = 1'b0;
    end
    while (m_busy || busy) @(posedge clk);
    #2;
    if (ea < 0) begin
      chk(ld_cr3 === rd(nb + 32'(B_CR3*4)), "R8", "ld_cr3", ld_cr3, rd(nb + 32'(B_CR3*4)));
      chk(ld_eip === rd(nb + 32'(B_EIP*4)), "R8", "ld_eip", ld_eip, rd(nb + 32'(B_EIP*4)));
      chk(ld_eflags === rd(nb + 32'(B_EFL*4)), "R8", "ld_eflags", ld_eflags, rd(nb + 32'(B_EFL*4)));
      for (int i = 0; i < 8; i++)
        chk(ld_gpr[i*32 +: 32] === rd(nb + 32'((B_GPR+i)*4)), "R8", "ld_gpr", ld_gpr[i*32 +: 32], rd(nb + 32'((B_GPR+i)*4)));
      for (int i = 0; i < 6; i++)
        chk(ld_seg[i*16 +: 16] === rd(nb + 32'((B_SEG+i)*4)) % 65536, "R8", "ld_seg",
            32'(ld_seg[i*16 +: 16]), rd(nb + 32'((B_SEG+i)*4)) & 32'hFFFF);
      chk(ld_ldt === rd(nb + 32'(B_LDT*4)) % 65536, "R8", "ld_ldt", 32'(ld_ldt), rd(nb + 32'(B_LDT*4)) & 32'hFFFF);
      if (c == 2'd0)
        chk(rd(nb) === dflt(nb), "R5", "link word after jump", rd(nb), dflt(nb));
      else
        chk(rd(nb) === {16'h0, sel}, "R5", "link word after call/interrupt", rd(nb), {16'h0, sel});
    end else begin
      chk(fault === 1'b1, "R10", "fault level", 32'(fault), 32'd1);
      repeat (5) @(posedge clk);
      #2 chk(mem_req === 1'b0 && fault === 1'b1, "R10", "quiet after error", 32'(mem_req), 32'd0);
    end
    for (int w = 1; w <= 6; w++) begin
      chk(rd(ob + 32'(w*4)) === dflt(ob + 32'(w*4)), "R6", "old stack word", rd(ob + 32'(w*4)), dflt(ob + 32'(w*4)));
      chk(rd(nb + 32'(w*4)) === dflt(nb + 32'(w*4)), "R6", "new stack word", rd(nb + 32'(w*4)), dflt(nb + 32'(w*4)));
    end
    chk(rd(ob + 32'(B_IOMAP*4)) === dflt(ob + 32'(B_IOMAP*4)), "R6", "old io map ptr", rd(ob + 32'(B_IOMAP*4)), dflt(ob + 32'(B_IOMAP*4)));
    chk(rd(nb + 32'(B_IOMAP*4)) === dflt(nb + 32'(B_IOMAP*4)), "R6", "new io map ptr", rd(nb + 32'(B_IOMAP*4)), dflt(nb + 32'(B_IOMAP*4)));
    chk(rd(nb + 32'(B_CR3*4)) === dflt(nb + 32'(B_CR3*4)), "R6", "cr3 word unwritten", rd(nb + 32'(B_CR3*4)), dflt(nb + 32'(B_CR3*4)));
    chk(rd(nb + 32'(B_LDT*4)) === dflt(nb + 32'(B_LDT*4)), "R6", "ldt word unwritten", rd(nb + 32'(B_LDT*4)), dflt(nb + 32'(B_LDT*4)));
    chk(rd(ob) === dflt(ob), "R6", "old link unwritten", rd(ob), dflt(ob));
    repeat (3) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk(busy === 1'b0 && done === 1'b0, "R1", "busy/done in reset", {30'h0, busy, done}, '0);
    chk(fault === 1'b0 && mem_req === 1'b0, "R1", "fault/req in reset", {30'h0, fault, mem_req}, '0);
    rst_n = 1'b1;
    @(posedge clk); #2;
    chk(busy === 1'b0 && mem_req === 1'b0 && fault === 1'b0, "R1", "idle after reset", {29'h0, busy, mem_req, fault}, '0);
    run(0, 2'd1, 0, -1, 1'b0);
    run(1, 2'd0, 1, -1, 1'b0);
    run(2, 2'd2, 2, -1, 1'b1);
    run(3, 2'd0, 3, -1, 1'b1);
    run(4, 2'd1, 0, 5, 1'b0);
    run(5, 2'd3, 1, -1, 1'b0);
    run(6, 2'd2, 2, 20, 1'b0);
    run(7, 2'd0, 3, 16, 1'b0);
    run(8, 2'd0, 0, -1, 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule